// File: doc/BRIEF.md
# Four-Context Issue Scheduler for a Dual-Pipe In-Order Core

This block decides, on every clock, which of four hardware thread contexts may send work into a core that has two in-order scalar pipes, named U and V. Each context has a small queue of prefetched instruction bundles. The front end loads these queues through one refill port. A per-context stall input, driven by the hazard logic, holds a context back. A bundle carries the U-pipe instruction, the V-pipe instruction and a flag that says whether the two may pair.

The decoder takes two cycles, so a context that issued in one cycle may not issue in the next. The scheduler walks the contexts in a fixed circular order. It starts from the context after the last one that issued and takes the first eligible one. It pops that context's oldest bundle and shows the U instruction. It also shows the V instruction when the pairing flag is set. One thread on its own can therefore use at most every other cycle. Two or more ready threads fill every slot.

All outputs are combinational from the registered state and the stall inputs. The pop and any refill take effect at the next rising edge.

Top module: `issue_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, every queue is empty, so `fill_ready` is all ones and `iss_valid` is low. The search pointer starts at context 0, and no context counts as the last issuer.
- R2: A context is eligible only when its queue holds at least one bundle, its `stall` bit is low, and it was not the issuer in the previous cycle.
- R3: The search starts at the pointer and runs upward, wrapping from 3 to 0. It grants the first eligible context. After context c issues, the pointer becomes c+1 modulo 4.
- R4: The same context never shows `iss_valid` in two consecutive cycles.
- R5: With exactly one context kept supplied and unstalled, it issues in exactly half of the cycles of any window of even length.
- R6: In a cycle with no eligible context, `iss_valid` is low, the pointer keeps its value, and the previous-issuer block is cleared for the next cycle.
- R7: `iss_v_valid` is high only when `iss_valid` is high and the popped bundle's pair flag (`fill_pair` at refill) is 1. `iss_v` then carries that bundle's V instruction and is zero otherwise.
- R8: Each queue holds at most two bundles. `fill_ready[c]` is low when queue c is full. A refill to a full queue is dropped and never issues.
- R9: A refill to a queue that holds one bundle is accepted in the same cycle that this queue's bundle is popped.
- R10: Each context issues its bundles in refill order. `iss_u` carries the popped bundle's U instruction, and is zero when `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fill_valid | input | 1 | A refill bundle is offered this cycle |
| fill_ctx | input | 2 | Context the refill is for |
| fill_u | input | 32 | U-pipe instruction of the refill bundle |
| fill_v | input | 32 | V-pipe instruction of the refill bundle |
| fill_pair | input | 1 | The two instructions of the bundle may issue together |
| fill_ready | output | 4 | Per context: its queue has room for a refill |
| stall | input | 4 | Per context: hazard logic holds this context back |
| iss_valid | output | 1 | A bundle issues this cycle |
| iss_ctx | output | 2 | Context that issues |
| iss_u | output | 32 | Instruction for the U pipe |
| iss_v_valid | output | 1 | The V pipe also receives an instruction |
| iss_v | output | 32 | Instruction for the V pipe |

## Verification
The properties assume that `stall` and the refill inputs are known and are stable across the sampling edge. They also assume that `fill_ctx` always names one of the four contexts. Refills aimed at full queues are treated as legal input that the block must drop. The stimulus changes inputs only on the falling clock edge and draws `fill_ctx` from 0 to 3. It deliberately aims refills at full queues during an all-stalled phase and during random traffic. This way the drop path, and the path where a refill meets a pop on the same queue, are both exercised under the same input assumptions.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int INSTR_W = 32;

    typedef logic [INSTR_W-1:0] instr_t;

    typedef struct packed {
        logic   pair;
        instr_t v;
        instr_t u;
    } bundle_t;

    // circular add: (a + b) mod n, for a < n and b < n
    function automatic int unsigned wrap_add(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned n);
        int unsigned s;
        s = a + b;
        return (s >= n) ? s - n : s;
    endfunction

endpackage

// File: rtl/ctx_buffer.sv
module ctx_buffer
    import sched_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int NW = $clog2(DEPTH + 1)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  logic    pop,
    input  bundle_t din,
    output bundle_t head,
    output logic    nonempty,
    output logic    notfull
);

    bundle_t         mem [DEPTH];
    logic [PW-1:0]   rd_q, wr_q;
    logic [NW-1:0]   cnt_q;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_q] <= din;
                wr_q      <= step_ptr(wr_q);
            end
            if (pop) rd_q <= step_ptr(rd_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head     = mem[rd_q];
    assign nonempty = (cnt_q != '0);
    assign notfull  = (cnt_q != NW'(DEPTH));

endmodule

// File: rtl/rr_picker.sv
module rr_picker
    import sched_pkg::*;
#(
    parameter int NCTX = 4,
    localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic [NCTX-1:0] elig,
    input  logic [CW-1:0]   start,
    output logic            gnt_valid,
    output logic [CW-1:0]   gnt_idx
);

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 0; k < NCTX; k++) begin
            int unsigned c;
            c = wrap_add(32'(start), k, NCTX);
            if (!gnt_valid && elig[c]) begin
                gnt_valid = 1'b1;
                gnt_idx   = CW'(c);
            end
        end
    end

endmodule

// File: rtl/issue_sched.sv
module issue_sched
    import sched_pkg::*;
#(
    parameter int NCTX  = 4,
    parameter int DEPTH = 2,
    localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fill_valid,
    input  logic [CW-1:0]              fill_ctx,
    input  logic [sched_pkg::INSTR_W-1:0] fill_u,
    input  logic [sched_pkg::INSTR_W-1:0] fill_v,
    input  logic                       fill_pair,
    output logic [NCTX-1:0]            fill_ready,
    input  logic [NCTX-1:0]            stall,
    output logic                       iss_valid,
    output logic [CW-1:0]              iss_ctx,
    output logic [sched_pkg::INSTR_W-1:0] iss_u,
    output logic                       iss_v_valid,
    output logic [sched_pkg::INSTR_W-1:0] iss_v
);

    bundle_t          fill_b;
    bundle_t          head [NCTX];
    bundle_t          sel_b;
    logic [NCTX-1:0]  nonempty, notfull, push, pop;
    logic [NCTX-1:0]  blocked, elig;
    logic [CW-1:0]    rr_ptr, last_idx;
    logic             last_vld;
    logic             gnt_valid;
    logic [CW-1:0]    gnt_idx;

    assign fill_b = '{pair: fill_pair, v: fill_v, u: fill_u};

    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        assign push[g]    = fill_valid && (fill_ctx == CW'(g)) && notfull[g];
        assign pop[g]     = gnt_valid && (gnt_idx == CW'(g));
        assign blocked[g] = last_vld && (last_idx == CW'(g));
        ctx_buffer #(.DEPTH(DEPTH)) u_buf (
            .clk      (clk),
            .rst      (rst),
            .push     (push[g]),
            .pop      (pop[g]),
            .din      (fill_b),
            .head     (head[g]),
            .nonempty (nonempty[g]),
            .notfull  (notfull[g])
        );
    end

    assign elig = nonempty & ~stall & ~blocked;

    rr_picker #(.NCTX(NCTX)) u_pick (
        .elig      (elig),
        .start     (rr_ptr),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr   <= '0;
            last_vld <= 1'b0;
            last_idx <= '0;
        end else begin
            last_vld <= gnt_valid;
            if (gnt_valid) begin
                last_idx <= gnt_idx;
                rr_ptr   <= CW'(wrap_add(32'(gnt_idx), 1, NCTX));
            end
        end
    end

    assign sel_b       = head[gnt_idx];
    assign fill_ready  = notfull;
    assign iss_valid   = gnt_valid;
    assign iss_ctx     = gnt_idx;
    assign iss_u       = gnt_valid ? sel_b.u : '0;
    assign iss_v_valid = gnt_valid && sel_b.pair;
    assign iss_v       = (gnt_valid && sel_b.pair) ? sel_b.v : '0;

endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
    parameter int NCTX = 4,
    localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic [NCTX-1:0] stall,
    input logic [NCTX-1:0] fill_ready,
    input logic            iss_valid,
    input logic [CW-1:0]   iss_ctx,
    input logic            iss_v_valid,
    input logic [CW-1:0]   rr_ptr
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!iss_valid && (&fill_ready)));

    // R2
    stalled_issue_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> !stall[iss_ctx]);

    // R4
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && $past(iss_valid)) |-> (iss_ctx != $past(iss_ctx)));

    // R6
    idle_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |=> $stable(rr_ptr));

    // R7
    vslot_chk: assert property (@(posedge clk) disable iff (rst)
        iss_v_valid |-> iss_valid);

endmodule

bind issue_sched sched_chk #(.NCTX(NCTX)) u_sched_chk (
    .clk         (clk),
    .rst         (rst),
    .stall       (stall),
    .fill_ready  (fill_ready),
    .iss_valid   (iss_valid),
    .iss_ctx     (iss_ctx),
    .iss_v_valid (iss_v_valid),
    .rr_ptr      (rr_ptr)
);

// File: tb/test_issue_sched.sv
module test_issue_sched;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fill_valid = 1'b0;
    logic [1:0]  fill_ctx = '0;
    logic [31:0] fill_u = '0;
    logic [31:0] fill_v = '0;
    logic        fill_pair = 1'b0;
    logic [3:0]  fill_ready;
    logic [3:0]  stall = '0;
    logic        iss_valid;
    logic [1:0]  iss_ctx;
    logic [31:0] iss_u;
    logic        iss_v_valid;
    logic [31:0] iss_v;

    issue_sched i_issue_sched (
        .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_ctx(fill_ctx),
        .fill_u(fill_u), .fill_v(fill_v), .fill_pair(fill_pair),
        .fill_ready(fill_ready), .stall(stall), .iss_valid(iss_valid),
        .iss_ctx(iss_ctx), .iss_u(iss_u), .iss_v_valid(iss_v_valid), .iss_v(iss_v)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference model state: {pair, v, u} per queued bundle
    logic [64:0] mq [4][$];
    int  m_ptr = 0;
    int  m_last = -1;
    bit  r9_seen [4];
    int  prev_ctx = -1;
    bit  got_issue;
    int  seq = 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, compare, then advance model for the next rising edge
    task automatic step(input bit fv, input int fc, input bit fp, input logic [3:0] st,
                        input string vtag);
        bit ev;
        int ec;
        logic [64:0] hb;
        int sz_before;
        @(negedge clk);
        fill_valid = fv;
        fill_ctx   = 2'(fc);
        fill_u     = 32'(seq);
        fill_v     = ~32'(seq);
        fill_pair  = fp;
        stall      = st;
        seq++;
        #1;
        ev = 1'b0; ec = 0;
        for (int k = 0; k < 4; k++) begin
            int c;
            c = (m_ptr + k) % 4;
            if (!ev && mq[c].size() > 0 && !st[c] && c != m_last) begin
                ev = 1'b1; ec = c;
            end
        end
        hb = ev ? mq[ec][0] : '0;
        chk(vtag, 64'(iss_valid), 64'(ev));
        if (ev) chk("R3", 64'(iss_ctx), 64'(ec));
        chk("R10", 64'(iss_u), ev ? 64'(hb[31:0]) : 64'd0);
        chk("R7", 64'(iss_v_valid), 64'(ev && hb[64]));
        chk("R7", 64'(iss_v), (ev && hb[64]) ? 64'(hb[63:32]) : 64'd0);
        for (int c = 0; c < 4; c++)
            chk(r9_seen[c] ? "R9" : "R8", 64'(fill_ready[c]), 64'(mq[c].size() < 2));
        if (iss_valid) begin
            chk("R2", 64'(st[iss_ctx]), 64'd0);
            chk("R4", 64'(int'(iss_ctx) == prev_ctx), 64'd0);
        end
        prev_ctx  = iss_valid ? int'(iss_ctx) : -1;
        got_issue = ev;
        // model update
        for (int c = 0; c < 4; c++) r9_seen[c] = 1'b0;
        sz_before = fv ? mq[fc].size() : 0;
        if (ev) begin
            void'(mq[ec].pop_front());
            m_ptr  = (ec + 1) % 4;
            m_last = ec;
        end else begin
            m_last = -1;
        end
        if (fv && sz_before < 2) begin
            mq[fc].push_back({fp, ~32'(seq - 1), 32'(seq - 1)});
            if (ev && ec == fc && sz_before == 1) r9_seen[fc] = 1'b1;
        end
    endtask

    initial begin
        int n_iss;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk("R1", 64'(iss_valid), 64'd0);
        chk("R1", 64'(fill_ready), 64'hF);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", 64'(iss_valid), 64'd0);
        chk("R1", 64'(fill_ready), 64'hF);

        // R5: single supplied context issues every other cycle
        for (int i = 0; i < 4; i++) step(1'b1, 2, i[0], 4'h0, "R5");
        n_iss = 0;
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 2, i[1], 4'h0, "R5");
            if (iss_valid) n_iss++;
        end
        chk("R5", 64'(n_iss), 64'd10);

        // R3: all contexts supplied, rotation
        for (int i = 0; i < 16; i++) step(1'b1, i % 4, i[0], 4'h0, "R3");

        // R6 and R8: everything stalled, refills aimed at full queues are dropped
        for (int i = 0; i < 10; i++) step(1'b1, i % 4, 1'b1, 4'hF, "R6");
        for (int i = 0; i < 6; i++) step(1'b0, 0, 1'b0, 4'h0, "R6");

        // random traffic with partial stalls
        for (int i = 0; i < 400; i++) begin
            logic [3:0] st;
            st = 4'($urandom) & 4'($urandom);
            step(($urandom % 4) != 0, int'($urandom % 4), 1'($urandom), st, "R3");
        end

        // R9: context 1 holds one bundle, refill meets pop
        for (int i = 0; i < 12; i++) step(1'b0, 0, 1'b0, 4'h0, "R10");
        step(1'b1, 1, 1'b1, 4'hF, "R6");
        step(1'b1, 1, 1'b0, 4'h0, "R9");
        step(1'b0, 1, 1'b0, 4'h0, "R9");
        step(1'b0, 1, 1'b0, 4'h0, "R9");

        // drain
        for (int i = 0; i < 12; i++) step(1'b0, 0, 1'b0, 4'h0, "R10");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule